// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block turns one packed 32-bit timing word into the read-enable, write-enable and chip-enable waveforms of a NAND flash bus. Each field of the word is a phase length in system clock cycles. A client issues one request at a time: a write strobe, a read strobe, or a busy wait after a program or erase command. The block asserts chip enable, waits the programmed setup time, and then runs the phases for that request. When the request is done it returns to idle.

A state machine built around a single phase counter runs the sequence. The states are:

- `ST_IDLE`: waiting for a request.
- `ST_CE_SETUP`: chip-enable-to-access delay.
- `ST_TURN`: write-to-read bus turnaround gap.
- `ST_WR_LOW` and `ST_WR_HIGH`: the two halves of the write strobe.
- `ST_RD_LOW` and `ST_RD_HIGH`: the two halves of the read strobe.
- `ST_BSY_HOLD`: time during which the busy line is ignored.
- `ST_BSY_POLL`: wait for the device to report ready.

The transitions are:

- IDLE→CE_SETUP when a request is accepted.
- CE_SETUP→WR_LOW for a write.
- CE_SETUP→TURN for a read that follows a write.
- CE_SETUP→RD_LOW for any other read.
- CE_SETUP→BSY_HOLD for a busy wait.
- TURN→RD_LOW.
- WR_LOW→WR_HIGH→IDLE.
- RD_LOW→RD_HIGH→IDLE.
- BSY_HOLD→BSY_POLL, then BSY_POLL→IDLE once the busy line reads ready.

Every phase except `ST_BSY_POLL` leaves when its count expires.

The block does not compute field values from clock rates. It has no data path and no command decoding. It only provides data-drive and data-sample timing marks.

Top module: `nand_strobe_timer`

## Requirements
- R1: The timing word fields are at fixed bit positions:
  - write low time in [3:0];
  - write high time in [7:4];
  - read low time in [11:8];
  - read high time in [15:12];
  - turnaround in [18:16];
  - busy-ignore delay in [23:19];
  - chip-enable setup in [25:24].
  
  Bits [31:26] have no effect.
- R2: Each field value N gives a phase of N cycles. A value of 0 gives a phase of 1 cycle.
- R3: Every accepted request first drives ce_n low with both strobes high for the setup length. ce_n stays low until the request ends.
- R4: A write (req_kind 2'b00) drives we_n low for the write-low length and then high for the write-high length. wdata_oe is high in exactly the we_n-low cycles.
- R5: A read (req_kind 2'b01) drives re_n low for the read-low length and then high for the read-high length. rdata_sample pulses once, in the last re_n-low cycle.
- R6: A read whose most recent earlier strobe since reset was a write gets a gap of the turnaround length between setup and re_n low. A read after a read, or the first read after reset, gets no gap.
- R7: A busy wait (req_kind 2'b10) ignores busy_n for the busy-ignore length after setup. It then ends in the first cycle in which busy_n is sampled high (1 = ready).
- R8: The timing word is captured when a request is accepted. A change while a request runs takes effect only from the next request.
- R9: ready is high only in idle. A request is accepted only when ready is high, and req_kind 2'b11 is never accepted. done pulses for one cycle in the first idle cycle after a request.
- R10: After reset: ce_n, we_n and re_n are high, ready is high, and done, wdata_oe and rdata_sample are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_cfg | input | 32 | Packed phase lengths |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_kind | input | 2 | 00 write, 01 read, 10 busy wait, 11 none |
| busy_n | input | 1 | Device ready/busy line, 1 = ready |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable strobe, active low |
| re_n | output | 1 | Read enable strobe, active low |
| wdata_oe | output | 1 | Write data must be driven and held stable |
| rdata_sample | output | 1 | Read data capture point |
| ready | output | 1 | Idle, request may be issued |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Two events can fall in the same cycle:

- **Timing word and request.** A new timing word can arrive, and a further request can be raised, while a request is still running. The bench changes timing_cfg and pulses req_valid in the first active cycles of a write. It then judges that the write keeps its original phase lengths, that no extra request starts, and that the next write uses the new word.
- **Busy line and busy-ignore window.** The busy line can turn ready inside the window in which it must be ignored, or exactly as polling begins. The bench sweeps every busy-ignore length against several release points, before, at and after the end of the window. It judges each run by its total chip-enable length, which is computed arithmetically.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

    localparam int CNT_W = 5;
    localparam int CFG_W = 32;
    localparam int NUM_F = 7;

    localparam int F_WL  = 0;
    localparam int F_WH  = 1;
    localparam int F_RL  = 2;
    localparam int F_RH  = 3;
    localparam int F_TA  = 4;
    localparam int F_BD  = 5;
    localparam int F_CEA = 6;

    function automatic int f_lsb(input int idx);
        case (idx)
            F_WL:    return 0;
            F_WH:    return 4;
            F_RL:    return 8;
            F_RH:    return 12;
            F_TA:    return 16;
            F_BD:    return 19;
            default: return 24;
        endcase
    endfunction

    function automatic int f_width(input int idx);
        case (idx)
            F_TA:    return 3;
            F_BD:    return 5;
            F_CEA:   return 2;
            default: return 4;
        endcase
    endfunction

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CE_SETUP,
        ST_TURN,
        ST_WR_LOW,
        ST_WR_HIGH,
        ST_RD_LOW,
        ST_RD_HIGH,
        ST_BSY_HOLD,
        ST_BSY_POLL
    } strobe_st_t;

    typedef enum logic [1:0] {
        K_WRITE = 2'b00,
        K_READ  = 2'b01,
        K_BUSY  = 2'b10,
        K_NONE  = 2'b11
    } req_kind_t;

endpackage

// File: rtl/nand_tm_fields.sv
module nand_tm_fields #(
    parameter int CFG_W = nand_strobe_pkg::CFG_W,
    parameter int CNT_W = nand_strobe_pkg::CNT_W,
    parameter int NUM_F = nand_strobe_pkg::NUM_F
) (
    input  logic [CFG_W-1:0]            cfg,
    output logic [NUM_F-1:0][CNT_W-1:0] len
);

    // Each field is cut out of the word and widened; zero is lifted to one.
    for (genvar i = 0; i < NUM_F; i++) begin : g_field
        localparam int LSB = nand_strobe_pkg::f_lsb(i);
        localparam int W   = nand_strobe_pkg::f_width(i);
        logic [W-1:0] raw;
        assign raw    = cfg[LSB +: W];
        assign len[i] = (raw == '0) ? CNT_W'(1) : CNT_W'(raw);
    end

endmodule

// File: rtl/nand_phase_counter.sv
module nand_phase_counter #(
    parameter int CNT_W = nand_strobe_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // R2: a phase that has started never reloads past its own length.
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int CFG_W = nand_strobe_pkg::CFG_W,
    parameter int CNT_W = nand_strobe_pkg::CNT_W,
    parameter int NUM_F = nand_strobe_pkg::NUM_F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             busy_n,
    output logic             ce_n,
    output logic             we_n,
    output logic             re_n,
    output logic             wdata_oe,
    output logic             rdata_sample,
    output logic             ready,
    output logic             done
);
    import nand_strobe_pkg::*;

    strobe_st_t state, state_n;
    req_kind_t  kind_q;
    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_src;
    logic [NUM_F-1:0][CNT_W-1:0] len;
    logic       wr_last;
    logic       ph_last;
    logic       ph_load;
    logic [CNT_W-1:0] ph_val;
    logic       accept;

    // While idle the live word feeds the decoder; afterwards the captured copy.
    assign cfg_src = (state == ST_IDLE) ? timing_cfg : cfg_q;
    assign accept  = (state == ST_IDLE) && req_valid && (req_kind != K_NONE);

    nand_tm_fields #(.CFG_W(CFG_W), .CNT_W(CNT_W), .NUM_F(NUM_F)) u_fields (
        .cfg (cfg_src),
        .len (len)
    );

    nand_phase_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    // Next-state selection.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (accept) state_n = ST_CE_SETUP;
            ST_CE_SETUP: if (ph_last) begin
                unique case (kind_q)
                    K_WRITE: state_n = ST_WR_LOW;
                    K_READ:  state_n = wr_last ? ST_TURN : ST_RD_LOW;
                    default: state_n = ST_BSY_HOLD;
                endcase
            end
            ST_TURN:     if (ph_last) state_n = ST_RD_LOW;
            ST_WR_LOW:   if (ph_last) state_n = ST_WR_HIGH;
            ST_WR_HIGH:  if (ph_last) state_n = ST_IDLE;
            ST_RD_LOW:   if (ph_last) state_n = ST_RD_HIGH;
            ST_RD_HIGH:  if (ph_last) state_n = ST_IDLE;
            ST_BSY_HOLD: if (ph_last) state_n = ST_BSY_POLL;
            ST_BSY_POLL: if (busy_n)  state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // Length of the phase being entered; the counter holds length minus one.
    always_comb begin
        unique case (state_n)
            ST_CE_SETUP: ph_val = len[F_CEA] - 1'b1;
            ST_TURN:     ph_val = len[F_TA]  - 1'b1;
            ST_WR_LOW:   ph_val = len[F_WL]  - 1'b1;
            ST_WR_HIGH:  ph_val = len[F_WH]  - 1'b1;
            ST_RD_LOW:   ph_val = len[F_RL]  - 1'b1;
            ST_RD_HIGH:  ph_val = len[F_RH]  - 1'b1;
            ST_BSY_HOLD: ph_val = len[F_BD]  - 1'b1;
            default:     ph_val = '0;
        endcase
    end
    assign ph_load = (state_n != state);

    // State register with request capture and write-history flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= K_WRITE;
            cfg_q   <= '0;
            wr_last <= 1'b0;
            done    <= 1'b0;
        end else begin
            state <= state_n;
            done  <= (state != ST_IDLE) && (state_n == ST_IDLE);
            if (accept) begin
                kind_q <= req_kind_t'(req_kind);
                cfg_q  <= timing_cfg;
            end
            if (state_n == ST_WR_LOW && state != ST_WR_LOW) begin
                wr_last <= 1'b1;
            end else if (state_n == ST_RD_LOW && state != ST_RD_LOW) begin
                wr_last <= 1'b0;
            end
        end
    end

    // Output decode.
    always_comb begin
        ready        = (state == ST_IDLE);
        ce_n         = (state == ST_IDLE);
        we_n         = (state != ST_WR_LOW);
        wdata_oe     = (state == ST_WR_LOW);
        re_n         = (state != ST_RD_LOW);
        rdata_sample = (state == ST_RD_LOW) && ph_last;
    end

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    a_r3_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    a_r7_poll_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BSY_POLL && !busy_n) |=> (state == ST_BSY_POLL));

    a_r9_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    a_r5_sample_then_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_sample |=> re_n);

    // Marks the reserved upper bits as deliberately unread.
    logic unused_cfg_hi;
    assign unused_cfg_hi = ^cfg_q[CFG_W-1:26];

endmodule

// File: tb/nand_strobe_timer_tb.sv
module nand_strobe_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        busy_n = 1'b1;
    logic ce_n, we_n, re_n, wdata_oe, rdata_sample, ready, done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int m_pre, m_wl, m_rl, m_post, m_bad, m_scnt, m_sidx, m_total, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_strobe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg),
        .req_valid(req_valid), .req_kind(req_kind), .busy_n(busy_n),
        .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .wdata_oe(wdata_oe),
        .rdata_sample(rdata_sample), .ready(ready), .done(done)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] mk(input int wl, wh, rl, rh, ta, bd, cea, hi);
        return {hi[5:0], cea[1:0], bd[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issues one request and measures its waveform at falling edges.
    task automatic run_op(input logic [1:0] kind, input logic [31:0] cfg,
                          input int rel, input logic [31:0] cfg_mid, input bit inject);
        @(negedge clk);
        timing_cfg = cfg;
        req_kind   = kind;
        req_valid  = 1'b1;
        busy_n     = (kind == 2'b10 && rel >= 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        m_pre = 0; m_wl = 0; m_rl = 0; m_post = 0; m_bad = 0;
        m_scnt = 0; m_sidx = -1;
        for (int idx = 0; idx < 300; idx++) begin
            if (ce_n) begin
                m_total = idx;
                break;
            end
            if (!we_n) begin
                m_wl++;
                if (!wdata_oe) m_bad++;
            end else if (!re_n) begin
                m_rl++;
            end else if (m_wl == 0 && m_rl == 0) begin
                m_pre++;
            end else begin
                m_post++;
            end
            if (wdata_oe && we_n) m_bad++;
            if (rdata_sample) begin
                m_scnt++;
                m_sidx = idx;
            end
            if (inject && idx == 0) timing_cfg = cfg_mid;
            if (inject && idx == 1) begin
                req_valid = 1'b1;
                req_kind  = 2'b01;
            end
            if (inject && idx == 2) req_valid = 1'b0;
            if (kind == 2'b10 && idx == rel) busy_n = 1'b1;
            @(negedge clk);
        end
        m_done = done;
        busy_n = 1'b1;
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] ca, cb;
        int exp_t;
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10 ce_n", ce_n, 1);
        chk("R10 we_n", we_n, 1);
        chk("R10 re_n", re_n, 1);
        chk("R10 ready", ready, 1);
        chk("R10 done", done, 0);
        chk("R10 wdata_oe", wdata_oe, 0);
        chk("R10 rdata_sample", rdata_sample, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: write sweep; upper bits junk
        for (int wl = 0; wl < 16; wl++) begin
            for (int wh = 0; wh < 16; wh++) begin
                int cea = (wl + wh) % 4;
                run_op(2'b00, mk(wl, wh, 3, 3, 5, 7, cea, 6'h2a), -1, '0, 0);
                chk("R3 setup", m_pre, eff(cea));
                chk("R1 R2 R4 we low", m_wl, eff(wl));
                chk("R1 R2 R4 we high", m_post, eff(wh));
                chk("R4 wdata_oe", m_bad, 0);
                chk("R5 no sample on write", m_scnt, 0);
                chk("R9 done", m_done, 1);
            end
        end

        // R6: first read after writes pays turnaround; then reads sweep
        run_op(2'b01, mk(1, 1, 1, 1, 4, 1, 0, 0), -1, '0, 0);
        chk("R6 gap after write", m_pre, 1 + 4);
        for (int rl = 0; rl < 16; rl++) begin
            for (int rh = 0; rh < 16; rh++) begin
                int cea = (rl * 3 + rh) % 4;
                run_op(2'b01, mk(2, 2, rl, rh, 6, 3, cea, 6'h3f), -1, '0, 0);
                chk("R6 no gap read after read", m_pre, eff(cea));
                chk("R1 R5 re low", m_rl, eff(rl));
                chk("R1 R5 re high", m_post, eff(rh));
                chk("R5 one sample", m_scnt, 1);
                chk("R5 sample position", m_sidx, eff(cea) + eff(rl) - 1);
                chk("R9 done", m_done, 1);
            end
        end

        // R6 turnaround length sweep
        for (int ta = 0; ta < 8; ta++) begin
            for (int cea = 0; cea < 4; cea++) begin
                ca = mk(1, 1, 2, 1, ta, 2, cea, 0);
                run_op(2'b00, ca, -1, '0, 0);
                run_op(2'b10, ca, -1, '0, 0);
                run_op(2'b01, ca, -1, '0, 0);
                chk("R1 R6 gap length", m_pre, eff(cea) + eff(ta));
                chk("R6 re low after gap", m_rl, 2);
                run_op(2'b01, ca, -1, '0, 0);
                chk("R6 second read no gap", m_pre, eff(cea));
            end
        end

        // R7 busy-ignore sweep against release points
        for (int bd = 0; bd < 32; bd++) begin
            for (int k = 0; k < 5; k++) begin
                int rel;
                int cea = bd % 4;
                int hold;
                case (k)
                    0: rel = -1;
                    1: rel = 0;
                    2: rel = 3;
                    3: rel = 20;
                    default: rel = 45;
                endcase
                hold = eff(cea) + eff(bd);
                exp_t = ((rel > hold) ? rel : hold) + 1;
                run_op(2'b10, mk(1, 1, 1, 1, 1, bd, cea, 0), rel, '0, 0);
                chk("R1 R7 busy wait length", m_total, exp_t);
                chk("R7 no strobes", m_pre, exp_t);
                chk("R9 done", m_done, 1);
            end
        end

        // R8 R9: config change and extra request during a write
        ca = mk(5, 2, 1, 1, 1, 1, 1, 0);
        cb = mk(1, 1, 1, 1, 1, 1, 3, 0);
        run_op(2'b00, ca, -1, cb, 1);
        chk("R8 old setup kept", m_pre, 1);
        chk("R8 old we low kept", m_wl, 5);
        chk("R8 old we high kept", m_post, 2);
        @(negedge clk);
        chk("R9 extra request ignored", ce_n, 1);
        chk("R9 done single cycle", done, 0);
        run_op(2'b00, cb, -1, '0, 0);
        chk("R8 new setup used", m_pre, 3);
        chk("R8 new we low used", m_wl, 1);

        // R9: kind 11 not accepted
        @(negedge clk);
        req_kind  = 2'b11;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 kind 11 ce_n", ce_n, 1);
        chk("R9 kind 11 ready", ready, 1);

        // R6 R10: reset clears write history
        run_op(2'b00, mk(1, 1, 1, 1, 5, 1, 0, 0), -1, '0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 ready in reset", ready, 1);
        rst_n = 1'b1;
        run_op(2'b01, mk(1, 1, 1, 1, 5, 1, 0, 0), -1, '0, 0);
        chk("R6 no gap after reset", m_pre, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule